// File: doc/BRIEF.md
# Processor Sleep and Wake Controller

This block decides, cycle by cycle, whether a small processor core is asleep. The core's pipeline reports three things through single-cycle strobes: that a wait-for-interrupt or wait-for-event instruction has executed, that a send-event instruction has executed, and that an exception handler has returned to Thread mode. The interrupt controller supplies per-interrupt pending, enable and priority vectors, together with the current execution priority. From these inputs the block drives three outputs: a sleeping flag, a one-cycle wake pulse, and a request that the core take an exception.

Sleep can start in three ways. The first is a wait-for-interrupt instruction. The second is a handler return while the sleep-on-exit setting is on. The third is a wait-for-event instruction that finds no event latched. Each way of entering sleep has its own wake rule. Sleep entered by wait-for-interrupt or by sleep-on-exit ends only when an interrupt pending with enough priority to be taken. Sleep entered by wait-for-event also ends on an event. An event comes from the local send-event instruction, from an event line driven by another core, or, when notify-on-pending is enabled, from any interrupt that newly becomes pending. The interrupt mask flag stops the exception request but never stops a wake. Software can therefore run restore code before the handler executes.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, sleeping_o, wake_o and exc_req_o are 0 and the event latch is clear, so the first wait-for-event puts the core to sleep.
- R2: While awake, a wfi_i strobe sets sleeping_o on the next clock edge, unless a qualifying interrupt is pending. In that case sleeping_o stays 0 and no wake pulse is produced.
- R3: Interrupt k qualifies when three conditions all hold: irq_pend_i[k] is 1, irq_en_i[k] is 1, and its priority field irq_prio_i[k*PW +: PW] is numerically strictly less than cur_prio_i. A lower number means a more urgent interrupt.
- R4: Sleep entered by wait-for-interrupt or by sleep-on-exit does not end on a send-event, on an external event, or on a pending interrupt that does not qualify.
- R5: While awake, an exc_ret_i strobe with sleep_on_exit_i = 1 sets sleeping_o on the next edge. With sleep_on_exit_i = 0 the strobe has no effect.
- R6: On the edge after a wake condition is seen during sleep, sleeping_o falls and wake_o rises together. wake_o is high for exactly one cycle.
- R7: exc_req_o is 1 exactly when a qualifying interrupt exists, primask_i is 0, and the core is not sleeping. A qualifying interrupt still wakes the core while primask_i is 1.
- R8: A one-bit event latch is set by sev_i, by ext_evt_i, and, when sev_on_pend_i is 1, by any new pending interrupt. A wait-for-event that finds the latch set clears it and does not sleep.
- R9: Sleep entered by wait-for-event ends on a qualifying interrupt, on sev_i, or on ext_evt_i. The event that ends it is consumed.
- R10: When sev_on_pend_i is 1, a 0-to-1 change of any pending bit ends wait-for-event sleep, even if that interrupt is disabled or its priority is too low. A pending bit that stays high is not new. With sev_on_pend_i = 0, such a change does not wake the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wfi_i | input | 1 | Wait-for-interrupt executed (strobe) |
| wfe_i | input | 1 | Wait-for-event executed (strobe) |
| sev_i | input | 1 | Local send-event executed (strobe) |
| ext_evt_i | input | 1 | Event from another core |
| exc_ret_i | input | 1 | Exception return to Thread mode (strobe) |
| irq_pend_i | input | N_IRQ | Pending interrupt bits |
| irq_en_i | input | N_IRQ | Interrupt enable bits |
| irq_prio_i | input | N_IRQ*PRIO_W | Priority field per interrupt, interrupt k at [k*PRIO_W +: PRIO_W] |
| cur_prio_i | input | PRIO_W | Current execution priority |
| primask_i | input | 1 | Interrupt mask flag |
| sleep_on_exit_i | input | 1 | Sleep on return to Thread mode |
| sev_on_pend_i | input | 1 | Newly pending interrupts raise events |
| sleeping_o | output | 1 | Core is asleep |
| wake_o | output | 1 | One-cycle wake pulse |
| exc_req_o | output | 1 | Request to take an exception |

## Verification
The qualification rule is swept over every interrupt line, every enable value, every priority field and every current priority. In each case a wait-for-interrupt either completes at once or puts the core to sleep, and a qualifying interrupt then wakes it, so the strict-less-than boundary and the enable gate are tested separately. Event patterns cover each event source, latched both while awake and while asleep, to separate consuming the latch from waking. Other patterns check that events are ignored during wait-for-interrupt sleep. Pending-edge patterns compare a bit that rises against a bit that stays high, with the notify-on-pending setting both on and off. A masked wake is checked to produce a pulse while the exception request stays low.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef struct packed {
        logic asleep;
        logic by_wfe;
        logic wake;
        logic evt;
    } swc_state_t;
endpackage

// File: rtl/swc_irq_eval.sv
module swc_irq_eval #(
    parameter int N_IRQ  = 4,
    parameter int PRIO_W = 2
) (
    input  logic [N_IRQ-1:0]        pend_i,
    input  logic [N_IRQ-1:0]        en_i,
    input  logic [N_IRQ*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]       cur_i,
    output logic                    any_qual_o
);
    logic [N_IRQ-1:0] qual;

    // one comparator per interrupt line: enabled, pending, strictly more urgent
    for (genvar k = 0; k < N_IRQ; k++) begin : g_line
        assign qual[k] = pend_i[k] & en_i[k] & (prio_i[k*PRIO_W +: PRIO_W] < cur_i);
    end

    assign any_qual_o = |qual;
endmodule

// File: rtl/swc_pend_edge.sv
module swc_pend_edge #(
    parameter int N_IRQ = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_IRQ-1:0] pend_i,
    output logic             new_any_o
);
    logic [N_IRQ-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = pend_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    assign new_any_o = |(pend_i & ~prev_q);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
    parameter int N_IRQ  = 4,
    parameter int PRIO_W = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wfi_i,
    input  logic                    wfe_i,
    input  logic                    sev_i,
    input  logic                    ext_evt_i,
    input  logic                    exc_ret_i,
    input  logic [N_IRQ-1:0]        irq_pend_i,
    input  logic [N_IRQ-1:0]        irq_en_i,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
    input  logic [PRIO_W-1:0]       cur_prio_i,
    input  logic                    primask_i,
    input  logic                    sleep_on_exit_i,
    input  logic                    sev_on_pend_i,
    output logic                    sleeping_o,
    output logic                    wake_o,
    output logic                    exc_req_o
);
    import swc_pkg::*;

    swc_state_t st_d, st_q;
    logic any_qual;
    logic new_pend;
    logic evt_set;
    logic exit_sleep;

    swc_irq_eval #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_eval (
        .pend_i     (irq_pend_i),
        .en_i       (irq_en_i),
        .prio_i     (irq_prio_i),
        .cur_i      (cur_prio_i),
        .any_qual_o (any_qual)
    );

    swc_pend_edge #(.N_IRQ(N_IRQ)) u_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pend_i    (irq_pend_i),
        .new_any_o (new_pend)
    );

    assign evt_set    = sev_i | ext_evt_i | (sev_on_pend_i & new_pend);
    assign exit_sleep = exc_ret_i & sleep_on_exit_i;

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        if (st_q.asleep) begin
            if (st_q.by_wfe) begin
                // event-wait sleep: interrupt or event ends it, event is consumed
                if (any_qual || evt_set) begin
                    st_d.asleep = 1'b0;
                    st_d.wake   = 1'b1;
                    st_d.evt    = 1'b0;
                end
            end else begin
                // interrupt-wait sleep: events only accumulate
                st_d.evt = st_q.evt | evt_set;
                if (any_qual) begin
                    st_d.asleep = 1'b0;
                    st_d.wake   = 1'b1;
                end
            end
        end else begin
            st_d.evt = st_q.evt | evt_set;
            if (exit_sleep) begin
                st_d.asleep = 1'b1;
                st_d.by_wfe = 1'b0;
            end else if (wfi_i) begin
                if (!any_qual) begin
                    st_d.asleep = 1'b1;
                    st_d.by_wfe = 1'b0;
                end
            end else if (wfe_i) begin
                if (st_q.evt || evt_set) begin
                    st_d.evt = 1'b0;
                end else if (!any_qual) begin
                    st_d.asleep = 1'b1;
                    st_d.by_wfe = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sleeping_o = st_q.asleep;
    assign wake_o     = st_q.wake;
    assign exc_req_o  = any_qual & ~primask_i & ~st_q.asleep;

    p_wake_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |=> !wake_o);

    p_wake_from_sleep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.asleep && (any_qual || (st_q.by_wfe && evt_set))) |=> (wake_o && !sleeping_o));

    p_masked_no_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primask_i |-> !exc_req_o);

    p_exit_enters_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sleeping_o && exit_sleep) |=> sleeping_o);

    p_wfi_completes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sleeping_o && wfi_i && any_qual && !exit_sleep) |=> !sleeping_o);

    p_wfi_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sleeping_o && !st_q.by_wfe && !any_qual) |=> sleeping_o);

    p_wfe_consumes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sleeping_o && wfe_i && !wfi_i && !exit_sleep && st_q.evt) |=> (!sleeping_o && !st_q.evt));
endmodule

// File: tb/sleep_wake_ctrl_bench.sv
module sleep_wake_ctrl_bench;
    localparam int N  = 4;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfi = 0, wfe = 0, sev = 0, ext = 0, ret = 0;
    logic [N-1:0] pend = '0, en = '0;
    logic [N*PW-1:0] prio = '0;
    logic [PW-1:0] cur = '0;
    logic primask = 0, soe = 0, son = 0;
    logic sleeping, wake, req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sleep_wake_ctrl #(.N_IRQ(N), .PRIO_W(PW)) u_sleep_wake_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .wfi_i(wfi), .wfe_i(wfe), .sev_i(sev),
        .ext_evt_i(ext), .exc_ret_i(ret), .irq_pend_i(pend), .irq_en_i(en),
        .irq_prio_i(prio), .cur_prio_i(cur), .primask_i(primask),
        .sleep_on_exit_i(soe), .sev_on_pend_i(son),
        .sleeping_o(sleeping), .wake_o(wake), .exc_req_o(req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_wfi(); wfi = 1; step(); wfi = 0; endtask
    task automatic do_wfe(); wfe = 1; step(); wfe = 0; endtask
    task automatic do_sev(); sev = 1; step(); sev = 0; endtask
    task automatic do_ext(); ext = 1; step(); ext = 0; endtask
    task automatic do_ret(); ret = 1; step(); ret = 0; endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R1 sleeping", sleeping, 0);
        chk("R1 wake", wake, 0);
        chk("R1 exc_req", req, 0);
        do_wfe();
        chk("R1 wfe sleeps with clear latch", sleeping, 1);
        do_ext();
        chk("R9 ext event wakes wfe", wake, 1);
        chk("R6 sleeping cleared with pulse", sleeping, 0);
        step();
        chk("R6 pulse one cycle", wake, 0);

        // qualification sweep
        for (int k = 0; k < N; k++) begin
            for (int e = 0; e < 2; e++) begin
                for (int p = 0; p < (1 << PW); p++) begin
                    for (int c = 0; c < (1 << PW); c++) begin
                        logic q;
                        q = (e == 1) && (p < c);
                        pend = '0; pend[k] = 1'b1;
                        en = '0; en[k] = e[0];
                        for (int j = 0; j < N; j++) prio[j*PW +: PW] = PW'(p);
                        cur = PW'(c);
                        #1;
                        chk("R3 R7 exc_req matches qualification", req, q);
                        step();
                        do_wfi();
                        chk("R2 R3 wfi sleeps iff nothing qualifies", sleeping, !q);
                        chk("R2 no wake pulse on wfi", wake, 0);
                        if (!q) begin
                            step();
                            chk("R4 non-qualifying pending keeps sleep", sleeping, 1);
                            en[k] = 1'b1;
                            for (int j = 0; j < N; j++) prio[j*PW +: PW] = '0;
                            cur = '1;
                            step();
                            chk("R6 wake pulse on qualifying", wake, 1);
                            chk("R6 sleeping cleared", sleeping, 0);
                        end
                        pend = '0; en = '0; cur = '0; prio = '0;
                        step();
                        chk("R6 pulse ends", wake, 0);
                    end
                end
            end
        end

        // sleep-on-exit
        soe = 0; do_ret();
        chk("R5 return without setting ignored", sleeping, 0);
        soe = 1; do_ret(); soe = 0;
        chk("R5 return enters sleep", sleeping, 1);
        do_sev();
        chk("R4 sev ignored in wfi sleep", sleeping, 1);
        do_ext();
        chk("R4 ext ignored in wfi sleep", sleeping, 1);
        pend = 4'b0001; en = 4'b0001; cur = 2'd1;
        step();
        chk("R6 wake from exit sleep", wake, 1);
        pend = '0; en = '0; cur = '0;
        step();
        do_wfe();
        chk("R8 latched event consumed, no sleep", sleeping, 0);
        step();
        do_wfe();
        chk("R8 latch cleared, wfe sleeps", sleeping, 1);
        do_sev();
        chk("R9 sev wakes wfe", wake, 1);
        step();

        // mask flag
        primask = 1;
        do_wfi();
        chk("R7 wfi sleeps", sleeping, 1);
        pend = 4'b0010; en = 4'b0010; cur = 2'd2;
        step();
        chk("R7 masked interrupt still wakes", wake, 1);
        chk("R7 no request while masked", req, 0);
        primask = 0;
        #1;
        chk("R7 request after unmask", req, 1);
        pend = '0; en = '0; cur = '0;
        step(); step();

        // notify on pending
        son = 1;
        do_wfe();
        chk("R10 wfe sleeps", sleeping, 1);
        pend = 4'b0100;
        step();
        chk("R10 disabled new pending wakes", wake, 1);
        step();
        do_wfe();
        chk("R10 held pending is not new", sleeping, 1);
        step();
        chk("R10 still asleep", sleeping, 1);
        pend = '0; step();
        pend = 4'b0100; step();
        chk("R10 re-raised pending wakes", wake, 1);
        pend = '0; step();
        pend = 4'b1000; step();
        do_wfe();
        chk("R8 pending event latched while awake", sleeping, 0);
        son = 0;
        pend = '0; step();
        do_wfe();
        chk("R10 wfe sleeps setting off", sleeping, 1);
        pend = 4'b0100; step();
        chk("R10 new pending ignored when off", sleeping, 1);
        do_sev();
        chk("R9 sev wakes", wake, 1);
        step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule